// File: doc/BRIEF.md
# Branch-Count Speculation Throttle

This block sits in the fetch control path of a core and limits how far speculative fetch can run ahead of branch resolution. It counts the branches that have been fetched and are not yet resolved. In a reduced-speculation level, it stalls fetch once that count reaches the level's limit. The decision uses the raw count alone. No predictor confidence is involved.

A three-bit mode input picks one of two kinds of setting. The first is the unconstrained setting, in which the count never stalls fetch. The others are five reduced levels with limits of 8, 4, 3, 2 and 1 outstanding branches. The same mode also sets the rest of the speculation machinery:
- In the unconstrained setting, renamer checkpoints are enabled (16 of them), the fetch buffer may use 16 entries and 128 physical registers may be allocated.
- In any reduced level, checkpoints are off, so mispredictions recover at commit. The fetch buffer shrinks to the issue width of 4 entries, and the register limit drops to 64.

A squash reloads the count with the number of older branches that survive it. A change of mode is deferred until the count fits under the new limit, and fetch is held for the whole of that wait.

Top module: `spec_throttle`

## Requirements
- R1: While `rst` is high at a rising edge, every register is set as follows: the count is 0, the active setting is unconstrained, `fetch_stall_o` is 0, `ckpt_en_o` is 1, `ckpt_num_o` is 16, `fb_limit_o` is 16 and `preg_limit_o` is 128.
- R2: `mode_sel_i` encoding:
  - Code 0 is the unconstrained setting.
  - Codes 1, 2, 3, 4 and 5 are reduced levels with branch limits 8, 4, 3, 2 and 1.
  - Codes 6 and 7 act exactly like code 5.
- R3: At each edge without a squash, the branch count behaves as follows:
  - A fetched-branch pulse alone adds one.
  - A resolved-branch pulse alone subtracts one.
  - Both pulses together leave the count unchanged.
  - The count saturates at 2^CNT_W-1 and does not go below 0.
- R4: When `squash_i` is high at an edge, the count takes the value of `squash_keep_i`. This overrides any fetched or resolved pulse in the same cycle.
- R5: When the active setting is a reduced level, `fetch_stall_o` is 1 after an edge if the count after that edge is at or above that level's limit.
- R6: When the active setting is unconstrained and no mode change is waiting, `fetch_stall_o` is 0 whatever the count.
- R7: The configuration outputs follow the active setting:
  - In any reduced level: `ckpt_en_o` is 0, `ckpt_num_o` is 0, `fb_limit_o` is 4 and `preg_limit_o` is 64.
  - In the unconstrained setting: 1, 16, 16 and 128 respectively.
- R8: A requested reduced level becomes active at an edge only if the count held before that edge is at or below its limit. While the requested setting (after R2 mapping) differs from the active one, `fetch_stall_o` is 1.
- R9: A request for the unconstrained setting becomes active at the next edge regardless of the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_fetch_i | input | 1 | Pulse: one branch entered the front end |
| br_resolve_i | input | 1 | Pulse: one in-flight branch resolved |
| squash_i | input | 1 | Pipeline flush; reloads the count |
| squash_keep_i | input | CNT_W | Unresolved branches older than the squash point |
| mode_sel_i | input | 3 | Requested speculation setting (R2 encoding) |
| fetch_stall_o | output | 1 | Hold fetch |
| ckpt_en_o | output | 1 | Renamer checkpoints allowed |
| ckpt_num_o | output | CKPT_W | Usable checkpoint count |
| fb_limit_o | output | FB_W | Usable fetch-buffer entries |
| preg_limit_o | output | PREG_W | Usable physical registers |

## Verification
The hardest case to reach from the ports is a deferred mode change when the count sits far above the new limit, especially when the counter has hit saturation. The stimulus builds that case on purpose:
1. It drives a long run of fetched branches in the unconstrained setting, past the counter ceiling.
2. It then requests a tight level and resolves branches one at a time.
3. This exposes when the switch lands and confirms that the count did not wrap.

Random traffic with occasional squashes and mode changes then revisits deferred switches from many starting counts.

// File: rtl/spec_throttle_pkg.sv
package spec_throttle_pkg;

  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_FREE = 3'd0;
  localparam logic [MODE_W-1:0] MODE_MAXLVL = 3'd5;
  localparam int LIM_W = 4;

  // Codes beyond the deepest level fold onto it.
  function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] m);
    return (m > MODE_MAXLVL) ? MODE_MAXLVL : m;
  endfunction

  // Outstanding-branch limit of a level; 0 means no limit.
  function automatic logic [LIM_W-1:0] level_limit(input logic [MODE_W-1:0] m);
    logic [LIM_W-1:0] lim;
    case (m)
      3'd1:    lim = 4'd8;
      3'd2:    lim = 4'd4;
      3'd3:    lim = 4'd3;
      3'd4:    lim = 4'd2;
      3'd5:    lim = 4'd1;
      default: lim = 4'd0;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/st_branch_counter.sv
module st_branch_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_n_o,
  output logic [CNT_W-1:0] cnt_q_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load_i) begin
      cnt_n = load_val_i;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   cnt_n = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
        2'b01:   cnt_n = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

  assign cnt_n_o = cnt_n;
  assign cnt_q_o = cnt_q;

  a_r3_inc: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !dec_i && !load_i && cnt_q != CNT_TOP) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r3_both_hold: assert property (@(posedge clk) disable iff (rst)
    (inc_i && dec_i && !load_i) |=> $stable(cnt_q));
  a_r3_floor: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !inc_i && !load_i && cnt_q == '0) |=> cnt_q == '0);
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    load_i |=> cnt_q == $past(load_val_i));

endmodule

// File: rtl/st_mode_gate.sv
module st_mode_gate
  import spec_throttle_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] req_i,
  input  logic [CNT_W-1:0]  cnt_q_i,
  output logic [MODE_W-1:0] act_n_o,
  output logic [MODE_W-1:0] act_q_o,
  output logic              pend_n_o
);

  logic [MODE_W-1:0] req_f;
  logic [MODE_W-1:0] act_q;
  logic [MODE_W-1:0] act_n;
  logic              fits;

  assign req_f = fold_mode(req_i);
  assign fits  = (req_f == MODE_FREE) ||
                 (cnt_q_i <= CNT_W'(level_limit(req_f)));

  always_comb begin
    act_n = act_q;
    if (req_f != act_q && fits) act_n = req_f;
  end

  always_ff @(posedge clk) begin
    if (rst) act_q <= MODE_FREE;
    else     act_q <= act_n;
  end

  assign act_n_o  = act_n;
  assign act_q_o  = act_q;
  assign pend_n_o = (act_n != req_f);

  a_r8_switch_fits: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act_q) && act_q != MODE_FREE) |->
      $past(cnt_q_i) <= CNT_W'(level_limit(act_q)));
  a_r9_free_now: assert property (@(posedge clk) disable iff (rst)
    (fold_mode(req_i) == MODE_FREE) |=> act_q == MODE_FREE);
  a_r2_legal_mode: assert property (@(posedge clk) disable iff (rst)
    act_q <= MODE_MAXLVL);

endmodule

// File: rtl/st_config_regs.sv
module st_config_regs
  import spec_throttle_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int CKPT_W   = 5,
  parameter int FB_W     = 5,
  parameter int PREG_W   = 8,
  parameter int FREE_CKPT = 16,
  parameter int FREE_FB   = 16,
  parameter int FREE_PREG = 128,
  parameter int LOW_FB    = 4,
  parameter int LOW_PREG  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] act_n_i,
  input  logic              pend_n_i,
  input  logic [CNT_W-1:0]  cnt_n_i,
  output logic              stall_o,
  output logic              ckpt_en_o,
  output logic [CKPT_W-1:0] ckpt_num_o,
  output logic [FB_W-1:0]   fb_limit_o,
  output logic [PREG_W-1:0] preg_limit_o
);

  logic low;
  logic at_limit;
  logic stall_n;

  assign low      = (act_n_i != MODE_FREE);
  assign at_limit = low && (cnt_n_i >= CNT_W'(level_limit(act_n_i)));
  assign stall_n  = pend_n_i || at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_o      <= 1'b0;
      ckpt_en_o    <= 1'b1;
      ckpt_num_o   <= CKPT_W'(FREE_CKPT);
      fb_limit_o   <= FB_W'(FREE_FB);
      preg_limit_o <= PREG_W'(FREE_PREG);
    end else begin
      stall_o      <= stall_n;
      ckpt_en_o    <= !low;
      ckpt_num_o   <= low ? '0 : CKPT_W'(FREE_CKPT);
      fb_limit_o   <= low ? FB_W'(LOW_FB) : FB_W'(FREE_FB);
      preg_limit_o <= low ? PREG_W'(LOW_PREG) : PREG_W'(FREE_PREG);
    end
  end

  a_r7_low_set: assert property (@(posedge clk) disable iff (rst)
    !ckpt_en_o |-> (ckpt_num_o == '0 && fb_limit_o == FB_W'(LOW_FB) &&
                    preg_limit_o == PREG_W'(LOW_PREG)));
  a_r7_free_set: assert property (@(posedge clk) disable iff (rst)
    ckpt_en_o |-> (ckpt_num_o == CKPT_W'(FREE_CKPT) && fb_limit_o == FB_W'(FREE_FB) &&
                   preg_limit_o == PREG_W'(FREE_PREG)));

endmodule

// File: rtl/spec_throttle.sv
module spec_throttle
  import spec_throttle_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int FREE_CKPT = 16,
  parameter int FREE_FB   = 16,
  parameter int FREE_PREG = 128,
  parameter int LOW_FB    = 4,
  parameter int LOW_PREG  = 64,
  localparam int CKPT_W   = $clog2(FREE_CKPT + 1),
  localparam int FB_W     = $clog2(FREE_FB + 1),
  localparam int PREG_W   = $clog2(FREE_PREG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_fetch_i,
  input  logic              br_resolve_i,
  input  logic              squash_i,
  input  logic [CNT_W-1:0]  squash_keep_i,
  input  logic [2:0]        mode_sel_i,
  output logic              fetch_stall_o,
  output logic              ckpt_en_o,
  output logic [CKPT_W-1:0] ckpt_num_o,
  output logic [FB_W-1:0]   fb_limit_o,
  output logic [PREG_W-1:0] preg_limit_o
);

  logic [CNT_W-1:0]  cnt_n;
  logic [CNT_W-1:0]  cnt_q;
  logic [MODE_W-1:0] act_n;
  logic [MODE_W-1:0] act_q;
  logic              pend_n;

  st_branch_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .inc_i      (br_fetch_i),
    .dec_i      (br_resolve_i),
    .load_i     (squash_i),
    .load_val_i (squash_keep_i),
    .cnt_n_o    (cnt_n),
    .cnt_q_o    (cnt_q)
  );

  st_mode_gate #(.CNT_W(CNT_W)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .req_i    (mode_sel_i),
    .cnt_q_i  (cnt_q),
    .act_n_o  (act_n),
    .act_q_o  (act_q),
    .pend_n_o (pend_n)
  );

  st_config_regs #(
    .CNT_W(CNT_W), .CKPT_W(CKPT_W), .FB_W(FB_W), .PREG_W(PREG_W),
    .FREE_CKPT(FREE_CKPT), .FREE_FB(FREE_FB), .FREE_PREG(FREE_PREG),
    .LOW_FB(LOW_FB), .LOW_PREG(LOW_PREG)
  ) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .act_n_i      (act_n),
    .pend_n_i     (pend_n),
    .cnt_n_i      (cnt_n),
    .stall_o      (fetch_stall_o),
    .ckpt_en_o    (ckpt_en_o),
    .ckpt_num_o   (ckpt_num_o),
    .fb_limit_o   (fb_limit_o),
    .preg_limit_o (preg_limit_o)
  );

  a_r5_limit_stall: assert property (@(posedge clk) disable iff (rst)
    (act_q != MODE_FREE && cnt_q >= CNT_W'(level_limit(act_q))) |-> fetch_stall_o);
  a_r6_free_no_stall: assert property (@(posedge clk) disable iff (rst)
    (act_q == MODE_FREE && fold_mode($past(mode_sel_i)) == MODE_FREE) |-> !fetch_stall_o);
  a_r8_pending_stall: assert property (@(posedge clk) disable iff (rst)
    (act_q != fold_mode($past(mode_sel_i))) |-> fetch_stall_o);
  a_r7_mode_cfg: assert property (@(posedge clk) disable iff (rst)
    ckpt_en_o == (act_q == MODE_FREE));

endmodule

// File: tb/spec_throttle_tb_top.sv
`timescale 1ns/1ps
module spec_throttle_tb_top;

  localparam int CNT_W = 5;
  localparam int TOP = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             br_fetch_i = 1'b0;
  logic             br_resolve_i = 1'b0;
  logic             squash_i = 1'b0;
  logic [CNT_W-1:0] squash_keep_i = '0;
  logic [2:0]       mode_sel_i = 3'd0;
  logic             fetch_stall_o;
  logic             ckpt_en_o;
  logic [4:0]       ckpt_num_o;
  logic [4:0]       fb_limit_o;
  logic [7:0]       preg_limit_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_cnt;
  int m_act;
  int m_req;

  always #4 clk = ~clk;

  spec_throttle #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst),
    .br_fetch_i(br_fetch_i), .br_resolve_i(br_resolve_i),
    .squash_i(squash_i), .squash_keep_i(squash_keep_i),
    .mode_sel_i(mode_sel_i),
    .fetch_stall_o(fetch_stall_o), .ckpt_en_o(ckpt_en_o),
    .ckpt_num_o(ckpt_num_o), .fb_limit_o(fb_limit_o),
    .preg_limit_o(preg_limit_o)
  );

  function automatic int fold(input int m);
    return (m > 5) ? 5 : m;
  endfunction

  function automatic int lim(input int m);
    case (m)
      1: return 8;
      2: return 4;
      3: return 3;
      4: return 2;
      5: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_stall();
    return (m_act != m_req) || (m_act != 0 && m_cnt >= lim(m_act));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_cfg(input string tag);
    int low;
    int e_pack;
    int a_pack;
    low = (m_act != 0);
    e_pack = low ? {1'b0, 5'd0, 5'd4, 8'd64} : {1'b1, 5'd16, 5'd16, 8'd128};
    a_pack = {ckpt_en_o, ckpt_num_o, fb_limit_o, preg_limit_o};
    check(a_pack == e_pack, tag, a_pack, e_pack);
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic step(input bit f, input bit r, input bit s, input int k, input int m);
    string tag;
    br_fetch_i = f;
    br_resolve_i = r;
    squash_i = s;
    squash_keep_i = CNT_W'(k);
    mode_sel_i = 3'(m);
    @(posedge clk);
    m_req = fold(m);
    if (m_req != m_act && (m_req == 0 || m_cnt <= lim(m_req))) m_act = m_req;
    if (s) m_cnt = k;
    else if (f && !r) m_cnt = (m_cnt == TOP) ? m_cnt : m_cnt + 1;
    else if (r && !f) m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
    @(negedge clk);
    if (s) tag = "R4 squash reload";
    else if (m_act != m_req) tag = "R8 deferred switch";
    else if (m_act == 0) tag = "R6 free no stall";
    else tag = "R5 level stall";
    check(fetch_stall_o == exp_stall(), tag, fetch_stall_o, exp_stall());
    check_cfg("R7 config");
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1f3a);
    m_cnt = 0; m_act = 0; m_req = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(fetch_stall_o == 1'b0, "R1 reset stall", fetch_stall_o, 0);
    check_cfg("R1 reset config");

    // R2 deepest level, immediate switch at count 0
    step(0, 0, 0, 0, 5);
    check(ckpt_en_o == 1'b0, "R2 level 5 active", ckpt_en_o, 0);
    step(1, 0, 0, 0, 5);
    check(fetch_stall_o == 1'b1, "R5 one branch at limit 1", fetch_stall_o, 1);
    step(0, 1, 0, 0, 5);
    check(fetch_stall_o == 1'b0, "R3 decrement", fetch_stall_o, 0);
    // R2 code 7 behaves like code 5
    step(0, 0, 0, 0, 7);
    check(fetch_stall_o == 1'b0, "R2 code 7 no pending", fetch_stall_o, 0);
    step(1, 0, 0, 0, 7);
    check(fetch_stall_o == 1'b1, "R2 code 7 limit 1", fetch_stall_o, 1);
    // R9 unconstrained switch with count above any limit
    step(0, 0, 0, 0, 0);
    check(ckpt_en_o == 1'b1 && fetch_stall_o == 1'b0, "R9 free at once", ckpt_en_o, 1);
    // R6 run past the ceiling
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 0);
    check(fetch_stall_o == 1'b0, "R6 no stall at saturation", fetch_stall_o, 0);
    // R8 deferred switch to level 1 (limit 8), count saturated at 31 (R3)
    for (int i = 0; i < 22; i++) step(0, 1, 0, 0, 1);
    check(ckpt_en_o == 1'b1 && fetch_stall_o == 1'b1, "R3 saturation still pending", ckpt_en_o, 1);
    step(0, 1, 0, 0, 1);
    check(ckpt_en_o == 1'b1, "R8 count 9 blocks switch", ckpt_en_o, 1);
    step(0, 0, 0, 0, 1);
    check(ckpt_en_o == 1'b0 && fetch_stall_o == 1'b1, "R8 switch at count 8", ckpt_en_o, 0);
    step(0, 1, 0, 0, 1);
    check(fetch_stall_o == 1'b0, "R5 below limit", fetch_stall_o, 0);
    step(1, 1, 0, 0, 1);
    check(fetch_stall_o == 1'b0, "R3 both pulses hold", fetch_stall_o, 0);
    step(1, 0, 0, 0, 1);
    check(fetch_stall_o == 1'b1, "R3 count back to 8", fetch_stall_o, 1);
    // R4 squash beats a same-cycle fetch
    step(1, 0, 1, 2, 1);
    check(fetch_stall_o == 1'b0, "R4 reload to 2", fetch_stall_o, 0);
    step(0, 0, 0, 0, 4);
    check(ckpt_en_o == 1'b0 && fetch_stall_o == 1'b1, "R4 count 2 at limit 2", fetch_stall_o, 1);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit f, r, s;
      int k, m;
      f = ($urandom % 100) < 40;
      r = ($urandom % 100) < 35;
      s = ($urandom % 100) < 3;
      k = $urandom % 13;
      m = (($urandom % 100) < 3) ? int'($urandom % 8) : int'(mode_sel_i);
      step(f, r, s, k, m);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule